// File: doc/BRIEF.md
# Unified multi-port reservation station

This block is a central scheduling pool for renamed micro-ops. The rename/issue stage hands it a group of up to `GROUP` micro-ops per cycle. Each micro-op carries a port class, a reorder-buffer tag, a destination tag, and two source operands. Each source arrives either as a value already read from the register file or reorder buffer, or as a tag it must wait for. The pool holds each micro-op until both sources are known. It then hands the micro-op to the one execution port its class names. Each port takes the oldest eligible micro-op of its class, so up to `NPORT` micro-ops leave in one cycle.

Results coming back from the execution units are driven on `NWB` broadcast channels. Every waiting source whose tag matches a broadcast copies the value. The same happens for a micro-op being written in that very cycle.

A flush removes every entry younger than a given reorder-buffer tag. The issue side is a valid/ready stream with these rules:
- the whole group is taken on a cycle where `in_ready` is high, and lanes whose `in_valid` is low are simply unused;
- nothing is taken while `in_ready` is low.

Each dispatch port is also a valid/ready stream. A port with `disp_ready` low keeps its micro-op. The only exception is that an older micro-op of the same class that becomes eligible may take its place at the output.

Top module: `rs_unified`

## Requirements
- R1: The pool holds `ENTRIES` micro-ops in one shared set of slots for all ports. An accepted micro-op occupies a free slot until it is dispatched or flushed, and a slot is never written while it is occupied.
- R2: A lane is accepted only on a rising clock edge where `in_valid` for that lane and `in_ready` are both high. While `in_ready` is low, offered micro-ops are dropped and never dispatched. Within one group, lane 0 is the oldest and higher lanes are younger.
- R3: `full` is high exactly when fewer than `GROUP` slots are free. `in_ready` equals `!full && !flush_valid`.
- R4: The class field is the port index. Port p only ever dispatches micro-ops whose class equals p, at most one per port per cycle, and all ports may dispatch in the same cycle.
- R5: Each port presents the oldest eligible micro-op of its class, where age is acceptance order.
- R6: A micro-op whose sources are both known at issue appears on its port in the cycle after acceptance. It stays presented while `disp_ready` is low, and leaves the pool on the edge where `disp_valid` and `disp_ready` are both high.
- R7: A waiting source whose tag equals a valid broadcast tag captures that broadcast's data. The micro-op becomes eligible in the next cycle, not in the broadcast cycle. A broadcast with a different tag has no effect.
- R8: A source that arrives unknown in the same cycle as a matching broadcast is captured on acceptance, so the micro-op is eligible in the next cycle.
- R9: While `flush_valid` is high, every entry whose reorder tag t satisfies (t − flush_rob) mod 2^ROBW in 1 … 2^(ROBW−1)−1 is removed and is not dispatched in that cycle. Entries with that tag or an older one remain, including across wrap of the tag space.
- R10: After reset the pool is empty, no port is valid, `in_ready` is high and `full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | GROUP | Per-lane issue valid |
| in_ready | output | 1 | Group accepted on this edge |
| full | output | 1 | Fewer than GROUP free slots |
| in_cls | input | GROUP×CLSW | Port class per lane |
| in_rob | input | GROUP×ROBW | Reorder-buffer tag per lane |
| in_dst | input | GROUP×TAGW | Destination tag per lane |
| in_src_rdy | input | GROUP×2 | Source value known at issue |
| in_src_tag | input | GROUP×2×TAGW | Source tag to wait for |
| in_src_val | input | GROUP×2×DATAW | Source value when known |
| wb_valid | input | NWB | Result broadcast valid |
| wb_tag | input | NWB×TAGW | Result broadcast tag |
| wb_data | input | NWB×DATAW | Result broadcast data |
| flush_valid | input | 1 | Remove entries younger than flush_rob |
| flush_rob | input | ROBW | Flush boundary tag |
| disp_valid | output | NPORT | Port has a micro-op |
| disp_ready | input | NPORT | Port takes the micro-op |
| disp_rob | output | NPORT×ROBW | Dispatched reorder tag |
| disp_dst | output | NPORT×TAGW | Dispatched destination tag |
| disp_src | output | NPORT×2×DATAW | Dispatched operand values |

## Verification
The bench builds the pool with 8 slots, 2 ports, an issue group of 2, 2 broadcast channels, 5-bit tags and 16-bit data. With 8 slots, the full threshold and back-pressure are reached after four issue cycles. Two ports are enough to show simultaneous dispatch and class separation. A 32-entry reorder tag space lets the flush be tested across the wrap from 31 to 0.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NSRC = 2;

  // True when a tag lies strictly after the boundary within half the tag space.
  function automatic logic is_younger(input logic [31:0] diff, input int w);
    logic [31:0] m;
    m = diff & ((32'd1 << w) - 32'd1);
    return (m != 32'd0) && !m[w-1];
  endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int ENTRIES = 36,
  parameter int GROUP   = 4,
  parameter int LW      = 2,
  parameter int CW      = 6
) (
  input  logic [ENTRIES-1:0]         busy,
  input  logic [GROUP-1:0]           lane_req,
  input  logic                       take,
  output logic [ENTRIES-1:0]         alloc,
  output logic [ENTRIES-1:0][LW-1:0] lane_of,
  output logic [CW-1:0]              free_cnt
);
  // Lane n of the group lands in the n-th free slot, counted from slot 0.
  always_comb begin
    int pos;
    pos      = 0;
    alloc    = '0;
    lane_of  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!busy[i]) begin
        if (pos < GROUP) begin
          lane_of[i] = LW'(pos);
          alloc[i]   = take & lane_req[LW'(pos)];
        end
        pos = pos + 1;
      end
    end
    free_cnt = CW'(pos);
  end
endmodule

// File: rtl/rs_snoop.sv
module rs_snoop #(
  parameter int NWB   = 6,
  parameter int TAGW  = 7,
  parameter int DATAW = 32
) (
  input  logic [TAGW-1:0]             tag,
  input  logic [NWB-1:0]              wb_valid,
  input  logic [NWB-1:0][TAGW-1:0]    wb_tag,
  input  logic [NWB-1:0][DATAW-1:0]   wb_data,
  output logic                        hit,
  output logic [DATAW-1:0]            data
);
  // Lowest-numbered matching channel wins if several carry the same tag.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int k = NWB - 1; k >= 0; k--) begin
      if (wb_valid[k] && wb_tag[k] == tag) begin
        hit  = 1'b1;
        data = wb_data[k];
      end
    end
  end
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter int ENTRIES = 36,
  parameter int LW      = 2,
  parameter int CLSW    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            alloc,
  input  logic [ENTRIES-1:0][LW-1:0]    lane_of,
  input  logic [ENTRIES-1:0]            busy,
  input  logic [ENTRIES-1:0]            cand,
  input  logic [ENTRIES-1:0][CLSW-1:0]  cls,
  output logic [ENTRIES-1:0]            pick
);
  // older[i][j] set: slot j was accepted before slot i.
  logic [ENTRIES-1:0][ENTRIES-1:0] older;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (alloc[i])
            older[i][j] <= busy[j] | (alloc[j] & (lane_of[j] < lane_of[i]));
          else if (alloc[j])
            older[i][j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && cand[j] && older[i][j] && cls[j] == cls[i])
          blk = 1'b1;
      end
      pick[i] = cand[i] & ~blk;
    end
  end
endmodule

// File: rtl/rs_unified.sv
module rs_unified import rs_pkg::*; #(
  parameter int ENTRIES = 36,
  parameter int NPORT   = 6,
  parameter int GROUP   = 4,
  parameter int NWB     = 6,
  parameter int TAGW    = 7,
  parameter int ROBW    = 7,
  parameter int DATAW   = 32,
  localparam int CLSW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [GROUP-1:0]                       in_valid,
  output logic                                   in_ready,
  output logic                                   full,
  input  logic [GROUP-1:0][CLSW-1:0]             in_cls,
  input  logic [GROUP-1:0][ROBW-1:0]             in_rob,
  input  logic [GROUP-1:0][TAGW-1:0]             in_dst,
  input  logic [GROUP-1:0][NSRC-1:0]             in_src_rdy,
  input  logic [GROUP-1:0][NSRC-1:0][TAGW-1:0]   in_src_tag,
  input  logic [GROUP-1:0][NSRC-1:0][DATAW-1:0]  in_src_val,
  input  logic [NWB-1:0]                         wb_valid,
  input  logic [NWB-1:0][TAGW-1:0]               wb_tag,
  input  logic [NWB-1:0][DATAW-1:0]              wb_data,
  input  logic                                   flush_valid,
  input  logic [ROBW-1:0]                        flush_rob,
  output logic [NPORT-1:0]                       disp_valid,
  input  logic [NPORT-1:0]                       disp_ready,
  output logic [NPORT-1:0][ROBW-1:0]             disp_rob,
  output logic [NPORT-1:0][TAGW-1:0]             disp_dst,
  output logic [NPORT-1:0][NSRC-1:0][DATAW-1:0]  disp_src
);
  localparam int LW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int CW = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0]                        busy, alloc, kill, cand, pick, fire;
  logic [ENTRIES-1:0][LW-1:0]                lane_of;
  logic [CW-1:0]                             free_cnt;
  logic [ENTRIES-1:0][CLSW-1:0]              cls_q;
  logic [ENTRIES-1:0][ROBW-1:0]              rob_q;
  logic [ENTRIES-1:0][TAGW-1:0]              dst_q;
  logic [ENTRIES-1:0][NSRC-1:0]              rdy_q, ent_hit;
  logic [ENTRIES-1:0][NSRC-1:0][TAGW-1:0]    tag_q;
  logic [ENTRIES-1:0][NSRC-1:0][DATAW-1:0]   val_q, ent_data;
  logic [GROUP-1:0][NSRC-1:0]                lane_hit;
  logic [GROUP-1:0][NSRC-1:0][DATAW-1:0]     lane_data;

  assign full     = free_cnt < CW'(GROUP);
  assign in_ready = ~full & ~flush_valid;

  rs_alloc #(.ENTRIES(ENTRIES), .GROUP(GROUP), .LW(LW), .CW(CW)) u_alloc (
    .busy(busy), .lane_req(in_valid), .take(in_ready),
    .alloc(alloc), .lane_of(lane_of), .free_cnt(free_cnt)
  );

  // Tag comparators for held sources and for sources arriving this cycle.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      rs_snoop #(.NWB(NWB), .TAGW(TAGW), .DATAW(DATAW)) u_snoop (
        .tag(tag_q[i][s]), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .hit(ent_hit[i][s]), .data(ent_data[i][s])
      );
    end
  end
  for (genvar g = 0; g < GROUP; g++) begin : g_lane
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      rs_snoop #(.NWB(NWB), .TAGW(TAGW), .DATAW(DATAW)) u_snoop (
        .tag(in_src_tag[g][s]), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .hit(lane_hit[g][s]), .data(lane_data[g][s])
      );
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      kill[i] = flush_valid & is_younger(32'(rob_q[i]) - 32'(flush_rob), ROBW);
      cand[i] = busy[i] & (&rdy_q[i]) & ~kill[i];
    end
  end

  rs_age #(.ENTRIES(ENTRIES), .LW(LW), .CLSW(CLSW)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .lane_of(lane_of), .busy(busy),
    .cand(cand), .cls(cls_q), .pick(pick)
  );

  // Per-port output mux: at most one picked slot per class.
  always_comb begin
    disp_valid = '0;
    disp_rob   = '0;
    disp_dst   = '0;
    disp_src   = '0;
    fire       = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (pick[i] && cls_q[i] == CLSW'(p)) begin
          disp_valid[p] = 1'b1;
          disp_rob[p]   = disp_rob[p] | rob_q[i];
          disp_dst[p]   = disp_dst[p] | dst_q[i];
          disp_src[p]   = disp_src[p] | val_q[i];
          fire[i]       = disp_ready[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= '0;
      rdy_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        busy[i] <= alloc[i] | (busy[i] & ~fire[i] & ~kill[i]);
        for (int s = 0; s < NSRC; s++) begin
          if (alloc[i])
            rdy_q[i][s] <= in_src_rdy[lane_of[i]][s] | lane_hit[lane_of[i]][s];
          else if (busy[i] && ent_hit[i][s])
            rdy_q[i][s] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc[i]) begin
        cls_q[i] <= in_cls[lane_of[i]];
        rob_q[i] <= in_rob[lane_of[i]];
        dst_q[i] <= in_dst[lane_of[i]];
      end
      for (int s = 0; s < NSRC; s++) begin
        if (alloc[i]) begin
          tag_q[i][s] <= in_src_tag[lane_of[i]][s];
          val_q[i][s] <= in_src_rdy[lane_of[i]][s] ? in_src_val[lane_of[i]][s]
                                                   : lane_data[lane_of[i]][s];
        end else if (busy[i] && !rdy_q[i][s] && ent_hit[i][s]) begin
          val_q[i][s] <= ent_data[i][s];
        end
      end
    end
  end
endmodule

// File: rtl/rs_unified_chk.sv
module rs_unified_chk #(
  parameter int ENTRIES = 36,
  parameter int NPORT   = 6,
  parameter int CLSW    = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_ready,
  input logic                          full,
  input logic                          flush_valid,
  input logic [NPORT-1:0]              disp_valid,
  input logic [NPORT-1:0]              disp_ready,
  input logic [ENTRIES-1:0]            busy,
  input logic [ENTRIES-1:0]            alloc,
  input logic [ENTRIES-1:0]            pick,
  input logic [ENTRIES-1:0][CLSW-1:0]  cls
);
  a_r3_full_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

  a_r9_flush_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !in_ready);

  a_r1_alloc_only_free: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc & busy) == '0);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [ENTRIES-1:0] mine;
    always_comb begin
      for (int i = 0; i < ENTRIES; i++) mine[i] = pick[i] && cls[i] == CLSW'(p);
    end

    a_r4_one_per_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mine));

    a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[p] && !disp_ready[p] && !flush_valid |=> disp_valid[p] || flush_valid);
  end
endmodule

bind rs_unified rs_unified_chk #(.ENTRIES(ENTRIES), .NPORT(NPORT), .CLSW(CLSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .full(full), .flush_valid(flush_valid),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .busy(busy), .alloc(alloc),
  .pick(pick), .cls(cls_q)
);

// File: tb/rs_unified_test.sv
module rs_unified_test;
  localparam int ENTRIES = 8, NPORT = 2, GROUP = 2, NWB = 2;
  localparam int TAGW = 5, ROBW = 5, DATAW = 16, CLSW = 1, NSRC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [GROUP-1:0]                       in_valid;
  logic                                   in_ready, full;
  logic [GROUP-1:0][CLSW-1:0]             in_cls;
  logic [GROUP-1:0][ROBW-1:0]             in_rob;
  logic [GROUP-1:0][TAGW-1:0]             in_dst;
  logic [GROUP-1:0][NSRC-1:0]             in_src_rdy;
  logic [GROUP-1:0][NSRC-1:0][TAGW-1:0]   in_src_tag;
  logic [GROUP-1:0][NSRC-1:0][DATAW-1:0]  in_src_val;
  logic [NWB-1:0]                         wb_valid;
  logic [NWB-1:0][TAGW-1:0]               wb_tag;
  logic [NWB-1:0][DATAW-1:0]              wb_data;
  logic                                   flush_valid;
  logic [ROBW-1:0]                        flush_rob;
  logic [NPORT-1:0]                       disp_valid, disp_ready;
  logic [NPORT-1:0][ROBW-1:0]             disp_rob;
  logic [NPORT-1:0][TAGW-1:0]             disp_dst;
  logic [NPORT-1:0][NSRC-1:0][DATAW-1:0]  disp_src;

  int n_chk = 0, n_fail = 0;
  int cnt;
  logic [31:0] seen;

  rs_unified #(.ENTRIES(ENTRIES), .NPORT(NPORT), .GROUP(GROUP), .NWB(NWB),
               .TAGW(TAGW), .ROBW(ROBW), .DATAW(DATAW)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear();
    in_valid = '0; in_cls = '0; in_rob = '0; in_dst = '0;
    in_src_rdy = '0; in_src_tag = '0; in_src_val = '0;
    wb_valid = '0; wb_tag = '0; wb_data = '0;
    flush_valid = 1'b0; flush_rob = '0;
  endtask

  task automatic put(input int l, input int c, input int rob, input int dst,
                     input logic r0, input int t0, input int v0,
                     input logic r1, input int t1, input int v1);
    in_valid[l] = 1'b1;
    in_cls[l] = CLSW'(c); in_rob[l] = ROBW'(rob); in_dst[l] = TAGW'(dst);
    in_src_rdy[l] = {r1, r0};
    in_src_tag[l][0] = TAGW'(t0); in_src_tag[l][1] = TAGW'(t1);
    in_src_val[l][0] = DATAW'(v0); in_src_val[l][1] = DATAW'(v1);
  endtask

  // Let port p drain for n cycles, counting handshakes and recording destinations.
  task automatic drain(input int p, input int n);
    cnt = 0; seen = '0;
    disp_ready[p] = 1'b1;
    for (int k = 0; k < n; k++) begin
      #1;
      if (disp_valid[p]) begin cnt++; seen[disp_dst[p]] = 1'b1; end
      cyc();
    end
    disp_ready = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 disp_valid", 32'(disp_valid), 0);
    chk("R10 in_ready", 32'(in_ready), 1);
    chk("R10 full", 32'(full), 0);
  endtask

  task automatic t_dispatch();
    put(0, 0, 1, 3, 1, 0, 'h1111, 1, 0, 'h2222);
    cyc(); clear(); #1;
    chk("R6 valid next cycle", 32'(disp_valid), 32'b01);
    chk("R6 dst", 32'(disp_dst[0]), 3);
    chk("R6 rob", 32'(disp_rob[0]), 1);
    chk("R6 src a", 32'(disp_src[0][0]), 'h1111);
    chk("R6 src b", 32'(disp_src[0][1]), 'h2222);
    cyc(); #1;
    chk("R6 held while stalled", 32'(disp_valid[0]), 1);
    disp_ready[0] = 1'b1;
    cyc(); disp_ready = '0; #1;
    chk("R6 leaves on handshake", 32'(disp_valid), 0);
  endtask

  task automatic t_oldest();
    put(0, 1, 2, 4, 1, 0, 1, 1, 0, 1);
    put(1, 1, 3, 5, 1, 0, 1, 1, 0, 1);
    cyc(); clear();
    put(0, 1, 4, 6, 1, 0, 1, 1, 0, 1);
    put(1, 0, 5, 7, 1, 0, 1, 1, 0, 1);
    cyc(); clear(); #1;
    chk("R4 both ports valid", 32'(disp_valid), 32'b11);
    chk("R4 port0 class0 only", 32'(disp_dst[0]), 7);
    chk("R5 R2 lane0 oldest", 32'(disp_dst[1]), 4);
    disp_ready = '1;
    cyc(); #1;
    chk("R5 second oldest", 32'(disp_dst[1]), 5);
    chk("R4 port0 emptied", 32'(disp_valid[0]), 0);
    cyc(); #1;
    chk("R5 youngest last", 32'(disp_dst[1]), 6);
    cyc(); #1;
    chk("R1 empty after drain", 32'(disp_valid), 0);
    disp_ready = '0;
  endtask

  task automatic t_wakeup();
    put(0, 0, 6, 8, 1, 0, 'hC0C0, 0, 9, 0);
    cyc(); clear(); disp_ready[0] = 1'b1; #1;
    chk("R7 waits for source", 32'(disp_valid[0]), 0);
    wb_valid[0] = 1'b1; wb_tag[0] = 5'd10; wb_data[0] = 'hBAD0;
    cyc(); clear(); #1;
    chk("R7 other tag ignored", 32'(disp_valid[0]), 0);
    wb_valid[1] = 1'b1; wb_tag[1] = 5'd9; wb_data[1] = 'hD00D; #1;
    chk("R7 not eligible in broadcast cycle", 32'(disp_valid[0]), 0);
    cyc(); clear(); #1;
    chk("R7 eligible next cycle", 32'(disp_valid[0]), 1);
    chk("R7 captured data", 32'(disp_src[0][1]), 'hD00D);
    chk("R7 known source kept", 32'(disp_src[0][0]), 'hC0C0);
    cyc(); disp_ready = '0;
  endtask

  task automatic t_bypass();
    put(0, 1, 7, 11, 0, 12, 0, 1, 0, 'hE0E0);
    wb_valid[0] = 1'b1; wb_tag[0] = 5'd12; wb_data[0] = 'hF00F;
    cyc(); clear(); #1;
    chk("R8 eligible after issue-cycle capture", 32'(disp_valid[1]), 1);
    chk("R8 captured data", 32'(disp_src[1][0]), 'hF00F);
    drain(1, 2);
  endtask

  task automatic t_full();
    for (int g = 0; g < 3; g++) begin
      put(0, 0, 8 + 2 * g, 16 + 2 * g, 1, 0, 1, 1, 0, 1);
      put(1, 0, 9 + 2 * g, 17 + 2 * g, 1, 0, 1, 1, 0, 1);
      cyc(); clear();
    end
    #1;
    chk("R3 two free not full", 32'(full), 0);
    chk("R3 ready with two free", 32'(in_ready), 1);
    put(0, 0, 14, 22, 1, 0, 1, 1, 0, 1);
    cyc(); clear(); #1;
    chk("R3 full with one free", 32'(full), 1);
    chk("R3 not ready when full", 32'(in_ready), 0);
    put(0, 0, 15, 23, 1, 0, 1, 1, 0, 1);
    put(1, 0, 16, 24, 1, 0, 1, 1, 0, 1);
    cyc(); clear();
    drain(0, 10);
    chk("R1 seven held", 32'(cnt), 7);
    chk("R2 refused lane0 dropped", 32'(seen[23]), 0);
    chk("R2 refused lane1 dropped", 32'(seen[24]), 0);
    #1;
    chk("R3 ready after drain", 32'(in_ready), 1);
  endtask

  task automatic t_flush();
    put(0, 0, 10, 1, 1, 0, 1, 1, 0, 1);
    put(1, 0, 11, 2, 1, 0, 1, 1, 0, 1);
    cyc(); clear();
    put(0, 0, 12, 13, 1, 0, 1, 1, 0, 1);
    put(1, 0, 13, 14, 1, 0, 1, 1, 0, 1);
    cyc(); clear();
    flush_valid = 1'b1; flush_rob = 5'd11;
    put(0, 0, 20, 15, 1, 0, 1, 1, 0, 1);
    #1;
    chk("R9 issue stalled during flush", 32'(in_ready), 0);
    chk("R9 older entry still presented", 32'(disp_dst[0]), 1);
    cyc(); clear();
    drain(0, 6);
    chk("R9 survivors", 32'(cnt), 2);
    chk("R9 boundary kept", 32'(seen[2]), 1);
    chk("R9 younger removed", 32'(seen[13] | seen[14]), 0);
    chk("R9 offered during flush dropped", 32'(seen[15]), 0);
    put(0, 0, 30, 3, 1, 0, 1, 1, 0, 1);
    put(1, 0, 31, 4, 1, 0, 1, 1, 0, 1);
    cyc(); clear();
    put(0, 0, 0, 5, 1, 0, 1, 1, 0, 1);
    cyc(); clear();
    flush_valid = 1'b1; flush_rob = 5'd31;
    cyc(); clear();
    drain(0, 6);
    chk("R9 wrap survivors", 32'(cnt), 2);
    chk("R9 wrapped younger removed", 32'(seen[5]), 0);
    chk("R9 wrap older kept", 32'(seen[3] & seen[4]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear(); disp_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dispatch();
    t_oldest();
    t_wakeup();
    t_bypass();
    t_full();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule